// File: doc/BRIEF.md
# ATA Task-File Command and Status Unit

This block is the device side of an ATA register window. A host reaches it through an 8-location I/O space addressed by a 3-bit offset. Through that space the host loads the sector count, the three address bytes and the device register. It then writes a command opcode. It follows the command through the status byte, the error byte and an interrupt line.

Three commands are executed: IDENTIFY, FLUSH CACHE and EXECUTE DIAGNOSTIC. IDENTIFY streams 256 words of identification data out of the data register; the words are computed from parameters. FLUSH CACHE is handed to a backend over a request/done handshake and keeps the device busy until the backend answers. EXECUTE DIAGNOSTIC completes at once and returns the device selection to device 0. Any other opcode is aborted.

Top module: `ata_taskfile_unit`

## Requirements
- R1: After reset the status byte (offset 7) reads 0x40, the error byte (offset 1) reads 0x00 and irq is low.
- R2: Bytes written at offsets 2 (sector count), 3, 4 and 5 (address low, mid and high) read back unchanged. A write at offset 1 (feature) does not alter the error byte read at offset 1.
- R3: The device register at offset 6 reads back the byte last written. Bit 4 (0x10) selects device 1 and bit 6 (0x40) requests LBA mode.
- R4: After opcode 0xEC is written at offset 7, irq rises. The status byte reads 0x48 (DRQ and DRDY set; BSY, DF and ERR clear) before each of 256 reads of offset 0. After the 256th read it reads 0x40.
- R5: Identification word 85 has bit 5 (0x20) set. Words 10 to 19 hold the 20-character serial text and words 23 to 26 hold the 8-character version text, two characters per word with the earlier character in bits 15:8. All other words read 0.
- R6: While opcode 0xE7 is outstanding, flush_req is high and the status byte reads 0xC0 (BSY and DRDY). One cycle with flush_done high ends the command: flush_req drops, the status byte reads 0x40 and irq rises.
- R7: Opcode 0x90 clears bit 4 of the device register, sets the error byte to 0x01 and raises irq.
- R8: A read of the status byte deasserts irq, unless an event that raises irq happens in the same cycle.
- R9: Any opcode other than 0xEC, 0xE7 and 0x90 gives status 0x41 (ERR with DRDY), error byte 0x04 (abort) and raises irq.
- R10: While BSY is set, a write at offset 7 has no effect on status, error byte or device register.
- R11: An accepted valid opcode clears ERR and the abort code left by an earlier aborted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset in the I/O window |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe (has side effects at offsets 0 and 7) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data for the offset on bus_addr, valid in the same cycle |
| irq | output | 1 | Interrupt request to the host |
| flush_req | output | 1 | Cache flush request to the backend, high while the flush is outstanding |
| flush_done | input | 1 | Backend completion pulse for the flush |

## Verification
The hardest state to reach from the ports is a command write that lands while the device is busy. In that state the opcode must be discarded without touching the error byte or the device selection. The bench holds flush_done low after issuing a flush, so the busy window stays open as long as needed. Inside it, the bench modifies the device register and issues a diagnostic and an illegal opcode, then reads everything back before releasing the backend. The other boundary is the 256th identification word, where DRQ must drop on exactly that read. The bench reads the status byte before every word to catch a drop that comes early or late.

// File: rtl/ata_taskfile_unit.sv
module ata_taskfile_unit #(
  parameter int          IDENT_WORDS  = 256,
  parameter logic [159:0] SERIAL_TEXT  = "UNIT-SN-0001        ",
  parameter logic [63:0]  VERSION_TEXT = "REV 1.0 "
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        flush_req,
  input  logic        flush_done
);
  localparam int IW        = $clog2(IDENT_WORDS);
  localparam int SER_WORDS = $bits(SERIAL_TEXT) / 16;
  localparam int VER_WORDS = $bits(VERSION_TEXT) / 16;
  localparam int SER_BASE  = 10;
  localparam int VER_BASE  = 23;
  localparam int CACHE_WORD = 85;
  localparam logic [7:0] OP_IDENT = 8'hEC;
  localparam logic [7:0] OP_FLUSH = 8'hE7;
  localparam logic [7:0] OP_DIAG  = 8'h90;
  localparam logic [7:0] ABORT_CODE = 8'h04;
  localparam logic [7:0] DIAG_PASS  = 8'h01;

  logic [7:0] nsect, lba_lo, lba_mid, lba_hi, dev_reg, err_reg;
  logic bsy, drq, err_bit;
  logic [IW-1:0] widx;

  wire cmd_wr    = bus_wr && bus_addr == 3'd7;
  wire cmd_go    = cmd_wr && !bsy;
  wire stat_rd   = bus_rd && bus_addr == 3'd7;
  wire data_rd   = bus_rd && bus_addr == 3'd0 && drq;
  wire last_word = widx == IW'(IDENT_WORDS - 1);
  wire flush_end = bsy && flush_done;
  wire op_known  = bus_wdata == OP_IDENT || bus_wdata == OP_FLUSH || bus_wdata == OP_DIAG;

  assign flush_req = bsy;

  function automatic logic [15:0] ident_word(input logic [IW-1:0] idx);
    int k;
    k = int'(idx);
    if (k >= SER_BASE && k < SER_BASE + SER_WORDS)
      return SERIAL_TEXT[$bits(SERIAL_TEXT) - 1 - 16 * (k - SER_BASE) -: 16];
    else if (k >= VER_BASE && k < VER_BASE + VER_WORDS)
      return VERSION_TEXT[$bits(VERSION_TEXT) - 1 - 16 * (k - VER_BASE) -: 16];
    else if (k == CACHE_WORD)
      return 16'h0020;
    else
      return 16'h0000;
  endfunction

  wire [7:0] status = {bsy, 1'b1, 1'b0, 1'b0, drq, 2'b00, err_bit};

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = drq ? ident_word(widx) : 16'h0000;
      3'd1:    bus_rdata = {8'h00, err_reg};
      3'd2:    bus_rdata = {8'h00, nsect};
      3'd3:    bus_rdata = {8'h00, lba_lo};
      3'd4:    bus_rdata = {8'h00, lba_mid};
      3'd5:    bus_rdata = {8'h00, lba_hi};
      3'd6:    bus_rdata = {8'h00, dev_reg};
      default: bus_rdata = {8'h00, status};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nsect <= '0; lba_lo <= '0; lba_mid <= '0; lba_hi <= '0;
      dev_reg <= '0; err_reg <= '0;
      bsy <= 1'b0; drq <= 1'b0; err_bit <= 1'b0; irq <= 1'b0;
      widx <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          3'd2: nsect   <= bus_wdata;
          3'd3: lba_lo  <= bus_wdata;
          3'd4: lba_mid <= bus_wdata;
          3'd5: lba_hi  <= bus_wdata;
          3'd6: dev_reg <= bus_wdata;
          default: ;
        endcase
      end
      if (stat_rd) irq <= 1'b0;
      if (data_rd) begin
        widx <= widx + 1'b1;
        if (last_word) drq <= 1'b0;
      end
      if (flush_end) begin
        bsy <= 1'b0;
        irq <= 1'b1;
      end
      if (cmd_go) begin
        drq <= 1'b0; err_bit <= 1'b0; err_reg <= '0;
        irq <= 1'b1; widx <= '0;
        case (bus_wdata)
          OP_IDENT: drq <= 1'b1;
          OP_FLUSH: begin bsy <= 1'b1; irq <= 1'b0; end
          OP_DIAG:  begin dev_reg[4] <= 1'b0; err_reg <= DIAG_PASS; end
          default:  begin err_bit <= 1'b1; err_reg <= ABORT_CODE; end
        endcase
      end
    end
  end

  AST_BSY_DRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bsy && drq)); // R6
  AST_IRQ_CLEAR_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !cmd_go && !flush_end |=> !irq); // R8
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bsy && cmd_wr && !flush_done |=> bsy && !drq && $stable(err_reg) && !err_bit); // R10
  AST_DIAG_DEV0: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && bus_wdata == OP_DIAG |=> !dev_reg[4] && err_reg == DIAG_PASS && irq); // R7
  AST_IDENT_END: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && last_word && !cmd_go |=> !drq); // R4
  AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && !op_known |=> err_bit && err_reg == ABORT_CODE && irq && !drq); // R9
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_end && !cmd_wr |=> !flush_req && irq); // R6
endmodule

// File: tb/ata_taskfile_unit_tb.sv
module ata_taskfile_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [159:0] SER = "UNIT-SN-0001        ";
  localparam logic [63:0]  VER = "REV 1.0 ";

  // {op(1: 0=write,1=read-check), addr(3), data(8), expected(8)}
  localparam int NVEC = 14;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 3'd2, 8'h12, 8'h00}, {1'b0, 3'd3, 8'h34, 8'h00},
    {1'b0, 3'd4, 8'h56, 8'h00}, {1'b0, 3'd5, 8'h78, 8'h00},
    {1'b0, 3'd6, 8'h50, 8'h00}, {1'b0, 3'd1, 8'hAB, 8'h00},
    {1'b1, 3'd2, 8'h00, 8'h12}, {1'b1, 3'd3, 8'h00, 8'h34},
    {1'b1, 3'd4, 8'h00, 8'h56}, {1'b1, 3'd5, 8'h00, 8'h78},
    {1'b1, 3'd6, 8'h00, 8'h50}, {1'b1, 3'd1, 8'h00, 8'h00},
    {1'b0, 3'd6, 8'h40, 8'h00}, {1'b1, 3'd6, 8'h00, 8'h40}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, flush_done = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq, flush_req;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ata_taskfile_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .flush_req(flush_req), .flush_done(flush_done));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  function automatic logic [15:0] exp_word(input int i);
    if (i >= 10 && i < 20) return SER[159 - 16 * (i - 10) -: 16];
    if (i >= 23 && i < 27) return VER[63 - 16 * (i - 23) -: 16];
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int stat_bad, data_bad;
    logic [15:0] w85, w10, w23;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(3'd7, v); check("R1 status", v, 16'h0040);
    rd(3'd1, v); check("R1 error", v, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'd0);

    for (int n = 0; n < NVEC; n++) begin
      if (VEC[n][19] == 1'b0) wr(VEC[n][18:16], VEC[n][15:8]);
      else begin
        rd(VEC[n][18:16], v);
        check(VEC[n][18:16] == 3'd6 ? "R3 device readback" : "R2 register readback",
              v, {8'h00, VEC[n][7:0]});
      end
    end

    wr(3'd7, 8'hEC);
    check("R4 identify irq", {15'd0, irq}, 16'd1);
    stat_bad = 0; data_bad = 0; w85 = '0; w10 = '0; w23 = '0;
    for (int i = 0; i < 256; i++) begin
      rd(3'd7, v);
      if (v !== 16'h0048) stat_bad++;
      rd(3'd0, v);
      if (v !== exp_word(i)) data_bad++;
      if (i == 85) w85 = v;
      if (i == 10) w10 = v;
      if (i == 23) w23 = v;
    end
    check("R4 status 0x48 before each word", 16'(stat_bad), 16'd0);
    check("R5 identify words", 16'(data_bad), 16'd0);
    check("R5 write cache bit", w85 & 16'h0020, 16'h0020);
    check("R5 serial first pair", w10, 16'h554E);
    check("R5 version first pair", w23, 16'h5245);
    rd(3'd7, v); check("R4 status after last word", v, 16'h0040);
    check("R8 irq cleared by status read", {15'd0, irq}, 16'd0);

    wr(3'd7, 8'h55);
    check("R9 abort irq", {15'd0, irq}, 16'd1);
    rd(3'd1, v); check("R9 abort code", v, 16'h0004);
    rd(3'd7, v); check("R9 abort status", v, 16'h0041);
    check("R8 irq after status read", {15'd0, irq}, 16'd0);

    wr(3'd6, 8'h50);
    rd(3'd6, v); check("R3 device 1 selected", v, 16'h0050);
    wr(3'd7, 8'h90);
    check("R7 diag irq", {15'd0, irq}, 16'd1);
    rd(3'd6, v); check("R7 device bit cleared", v, 16'h0040);
    rd(3'd1, v); check("R7 diag code", v, 16'h0001);
    rd(3'd7, v); check("R11 err cleared by valid command", v, 16'h0040);

    wr(3'd7, 8'hE7);
    check("R6 flush_req high", {15'd0, flush_req}, 16'd1);
    rd(3'd7, v); check("R6 status busy", v, 16'h00C0);
    check("R6 no irq while busy", {15'd0, irq}, 16'd0);
    wr(3'd6, 8'h50);
    wr(3'd7, 8'h90);
    rd(3'd6, v); check("R10 diag ignored while busy", v, 16'h0050);
    wr(3'd7, 8'h55);
    rd(3'd1, v); check("R10 abort ignored while busy", v, 16'h0000);
    rd(3'd7, v); check("R10 status unchanged while busy", v, 16'h00C0);
    check("R10 no irq from ignored writes", {15'd0, irq}, 16'd0);

    @(negedge clk); flush_done = 1'b1;
    @(posedge clk); #1 flush_done = 1'b0;
    check("R6 irq at completion", {15'd0, irq}, 16'd1);
    check("R6 flush_req dropped", {15'd0, flush_req}, 16'd0);
    rd(3'd7, v); check("R6 status after flush", v, 16'h0040);
    check("R8 irq cleared after flush", {15'd0, irq}, 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule